// File: doc/BRIEF.md
# Accessory ID and Charger Classifier

This block decides what has been plugged into a USB connector and what the port switches should do about it. Two detection paths feed it. The first path reads the resistance on the ID pin, which arrives as a 5-bit code from an external converter, together with a flag that says the pin is floating. The second path uses the VBUS-valid comparator and two data-line comparator flags: D+ shorted to D−, and host-side signalling seen during charger detection. Each path runs a timed sequence. When a sequence ends, the block registers a one-hot device type, the factory-mode JIG and BOOT requests and a routing request for the downstream switch controller. It also pulses a single-cycle attach or detach event.

Once a factory cable is recognised, detection stays active on the ID pin. Moving to another factory resistor switches mode and routing on the spot, with no detach and no new attach. Factory mode ends only after the ID pin has floated continuously for longer than the exit window. Every time constant is a parameter in milliseconds, and one more parameter sets the clock ticks per millisecond.

Top module: `acc_classifier`

## Requirements
- R1: After reset, dev_type is all zero, jig_req and boot_req are low, route_sel is 00 (open) and neither event output pulses.
- R2: A non-floating ID code held unchanged for ID_DET_MS (200 ms) is classified as follows, and attach_evt pulses once. Code 11000 sets dev_type bit 4 (factory USB, boot off). Code 11001 sets bit 5 (factory USB, boot on). Code 11100 sets bit 6 (factory UART, boot off). Code 11101 sets bit 7 (factory UART, boot on). In all four, jig_req is 1. boot_req is 1 only for 11001 and 11101. route_sel is 01 (primary host) for the two USB variants and 10 (secondary host) for the two UART variants.
- R3: Code 10111 sets dev_type bit 3 (charger adapter) with route_sel 00 only if vbus_ok is high when the window ends. Without VBUS, the same code is reported as unknown (bit 8).
- R4: Any other non-floating code (for example 10101, 11010, 11110 or 00000) sets dev_type bit 8 (unknown) with route_sel 00 and jig_req and boot_req low.
- R5: If the ID code changes during the 200 ms window, the window starts again from the new code.
- R6: In factory mode, a change to another factory code updates dev_type, jig_req, boot_req and route_sel within a few cycles, with no attach or detach event. A non-factory, non-floating code leaves the mode as it is, and so do changes of vbus_ok.
- R7: Factory mode is left only after the ID pin floats without a break for more than FLOAT_EXIT_MS (70 ms). The ID pin counts as floating when id_float is high or the code is 11111. A shorter float keeps the mode. On exit, detach_evt pulses and all outputs clear.
- R8: With the ID pin floating, VBUS valid and no data-line flag seen, dev_type bit 0 (standard port) is set with route_sel 01 and an attach pulse, 130 ms (SDP_MS) after VBUS becomes valid. Timing is accurate to within two clock cycles.
- R9: If host signalling is seen after the contact-detect phase and no short is seen, nothing is reported at 130 ms. At 170 ms (CDP_MS), dev_type bit 1 (charging downstream port) is set with route_sel 01.
- R10: If a D+/D− short is seen after the contact-detect phase, dev_type bit 2 (dedicated charger) is set at 170 ms with route_sel 00. The short takes priority over host signalling.
- R11: Data-line flags during the first 20 ms (DCD_MS) after VBUS becomes valid are ignored.
- R12: If VBUS is lost during USB detection, the block returns to standby with no event. If VBUS is lost after a USB attach, or the ID pin floats under a non-factory ID accessory, detach_evt pulses and the outputs clear.
- R13: dev_type never has more than one bit set. It only goes from non-zero to zero together with detach_evt. attach_evt and detach_evt are single-cycle and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_ok | input | 1 | VBUS-valid comparator flag |
| id_code | input | 5 | ID-pin resistance code; 11111 means floating |
| id_float | input | 1 | ID-pin floating flag |
| dline_short | input | 1 | D+ shorted to D− comparator flag |
| host_sig | input | 1 | Host-port signalling seen during charger detection |
| dev_type | output | 9 | One-hot device type (bit map in R2 to R4, R8 to R10) |
| jig_req | output | 1 | Factory JIG request |
| boot_req | output | 1 | Factory BOOT request |
| route_sel | output | 2 | 00 open, 01 primary host, 10 secondary host |
| attach_evt | output | 1 | One-cycle attach pulse |
| detach_evt | output | 1 | One-cycle detach pulse |

## Verification
The bench aims at the timing edges. It samples a few cycles before and after the 130 ms, 170 ms, 200 ms and 70 ms boundaries, so a design with an off-by-window counter reports too early or too late. It changes the factory code while the cable stays attached and counts event pulses, which catches a design that inserts a detach/attach pair or ignores the new code. It also checks the adapter code with and without VBUS, a short seen only during contact detect, a float shorter than the exit window, and a VBUS drop mid-detection. Those expose a missing VBUS qualifier, flags latched too early, a premature factory exit, and a spurious event on an aborted detection.

// File: rtl/acc_cls_pkg.sv
package acc_cls_pkg;

  localparam int NUM_TYPES      = 9;
  localparam int T_SDP          = 0;
  localparam int T_CDP          = 1;
  localparam int T_DCP          = 2;
  localparam int T_TA           = 3;
  localparam int T_FAC_USB_OFF  = 4;
  localparam int T_FAC_UART_ON  = 7;
  localparam int T_UNKNOWN      = 8;

  localparam logic [4:0] CODE_FLOAT = 5'b11111;
  localparam logic [4:0] CODE_TA    = 5'b10111;

  typedef logic [NUM_TYPES-1:0] dev_vec_t;

  typedef enum logic [1:0] {
    RT_OPEN      = 2'b00,
    RT_PRIMARY   = 2'b01,
    RT_SECONDARY = 2'b10
  } route_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ID_WAIT,
    S_ID_ATT,
    S_FACTORY,
    S_USB_DET,
    S_USB_ATT
  } state_e;

  typedef struct packed {
    dev_vec_t dev;
    logic     jig;
    logic     boot;
    route_e   route;
    logic     factory;
  } cls_t;

endpackage

// File: rtl/acc_id_decode.sv
module acc_id_decode
  import acc_cls_pkg::*;
(
  input  logic [4:0] code,
  input  logic       vbus_ok,
  output cls_t       cls
);

  logic [3:0] fac_hit;

  // Factory codes 11x0x: index {bit2, bit0} selects usb-off, usb-on, uart-off, uart-on
  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_fac
      localparam logic [4:0] FCODE = {2'b11, 1'(gi / 2), 1'b0, 1'(gi % 2)};
      assign fac_hit[gi] = (code == FCODE);
    end
  endgenerate

  always_comb begin
    cls       = '0;
    cls.route = RT_OPEN;
    if (|fac_hit) begin
      cls.factory                          = 1'b1;
      cls.jig                              = 1'b1;
      cls.dev[T_FAC_UART_ON:T_FAC_USB_OFF] = fac_hit;
      cls.boot                             = fac_hit[1] | fac_hit[3];
      cls.route                            = (fac_hit[2] | fac_hit[3]) ? RT_SECONDARY : RT_PRIMARY;
    end else if (code == CODE_TA && vbus_ok) begin
      cls.dev[T_TA] = 1'b1;
    end else begin
      cls.dev[T_UNKNOWN] = 1'b1;
    end
  end

endmodule

// File: rtl/acc_ms_timer.sv
module acc_ms_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;
  logic         inc_en;

  assign inc_en = ~&cnt;

  always_comb begin
    cnt_d = cnt;
    if (clr)         cnt_d = '0;
    else if (inc_en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/acc_bc_flags.sv
module acc_bc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sample_en,
  input  logic dline_short,
  input  logic host_sig,
  output logic seen_short,
  output logic seen_host
);

  logic short_d;
  logic host_d;

  always_comb begin
    short_d = seen_short;
    host_d  = seen_host;
    if (clr) begin
      short_d = 1'b0;
      host_d  = 1'b0;
    end else if (sample_en) begin
      short_d = seen_short | dline_short;
      host_d  = seen_host | host_sig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_short <= 1'b0;
      seen_host  <= 1'b0;
    end else begin
      seen_short <= short_d;
      seen_host  <= host_d;
    end
  end

endmodule

// File: rtl/acc_classifier.sv
module acc_classifier
  import acc_cls_pkg::*;
#(
  parameter int TICKS_PER_MS  = 1000,
  parameter int DCD_MS        = 20,
  parameter int SDP_MS        = 130,
  parameter int CDP_MS        = 170,
  parameter int ID_DET_MS     = 200,
  parameter int FLOAT_EXIT_MS = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbus_ok,
  input  logic [4:0] id_code,
  input  logic       id_float,
  input  logic       dline_short,
  input  logic       host_sig,
  output logic [8:0] dev_type,
  output logic       jig_req,
  output logic       boot_req,
  output logic [1:0] route_sel,
  output logic       attach_evt,
  output logic       detach_evt
);

  localparam int DCD_LIM = DCD_MS * TICKS_PER_MS;
  localparam int SDP_LIM = SDP_MS * TICKS_PER_MS;
  localparam int CDP_LIM = CDP_MS * TICKS_PER_MS;
  localparam int ID_LIM  = ID_DET_MS * TICKS_PER_MS;
  localparam int FLT_LIM = FLOAT_EXIT_MS * TICKS_PER_MS;
  localparam int MAX_A   = (ID_LIM > CDP_LIM) ? ID_LIM : CDP_LIM;
  localparam int TMAX    = (MAX_A > FLT_LIM) ? MAX_A : FLT_LIM;
  localparam int CW      = $clog2(TMAX + 2);

  localparam logic [CW-1:0] DCD_END = CW'(DCD_LIM);
  localparam logic [CW-1:0] SDP_END = CW'(SDP_LIM - 1);
  localparam logic [CW-1:0] CDP_END = CW'(CDP_LIM - 1);
  localparam logic [CW-1:0] ID_END  = CW'(ID_LIM - 1);
  localparam logic [CW-1:0] FLT_END = CW'(FLT_LIM);

  state_e     state_q, state_d;
  dev_vec_t   dev_q, dev_d;
  logic       jig_q, jig_d;
  logic       boot_q, boot_d;
  route_e     route_q, route_d;
  logic [4:0] code_q, code_d;
  logic       att_q, att_d;
  logic       det_q, det_d;

  logic          id_is_float;
  logic          tmr_clr;
  logic [CW-1:0] tmr_cnt;
  logic          seen_short, seen_host;
  logic          bc_clr, bc_sample;
  logic          do_detach, do_apply;
  cls_t          dec;

  assign id_is_float = id_float | (id_code == CODE_FLOAT);

  acc_id_decode u_dec (
    .code    (id_code),
    .vbus_ok (vbus_ok),
    .cls     (dec)
  );

  acc_ms_timer #(.W(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (tmr_cnt)
  );

  assign bc_clr    = (state_q != S_USB_DET);
  assign bc_sample = (state_q == S_USB_DET) && (tmr_cnt >= DCD_END);

  acc_bc_flags u_bc (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (bc_clr),
    .sample_en   (bc_sample),
    .dline_short (dline_short),
    .host_sig    (host_sig),
    .seen_short  (seen_short),
    .seen_host   (seen_host)
  );

  // Next-state and output logic
  always_comb begin
    state_d   = state_q;
    dev_d     = dev_q;
    jig_d     = jig_q;
    boot_d    = boot_q;
    route_d   = route_q;
    code_d    = code_q;
    att_d     = 1'b0;
    det_d     = 1'b0;
    tmr_clr   = 1'b0;
    do_detach = 1'b0;
    do_apply  = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (!id_is_float) begin
          state_d = S_ID_WAIT;
          tmr_clr = 1'b1;
          code_d  = id_code;
        end else if (vbus_ok) begin
          state_d = S_USB_DET;
          tmr_clr = 1'b1;
        end
      end

      S_ID_WAIT: begin
        if (id_is_float) begin
          state_d = S_IDLE;
        end else if (id_code != code_q) begin
          code_d  = id_code;
          tmr_clr = 1'b1;
        end else if (tmr_cnt >= ID_END) begin
          do_apply = 1'b1;
          att_d    = 1'b1;
          tmr_clr  = 1'b1;
          state_d  = dec.factory ? S_FACTORY : S_ID_ATT;
        end
      end

      S_ID_ATT: begin
        if (id_is_float || (dev_q[T_TA] && !vbus_ok)) do_detach = 1'b1;
      end

      S_FACTORY: begin
        if (id_is_float) begin
          if (tmr_cnt >= FLT_END) do_detach = 1'b1;
        end else begin
          tmr_clr = 1'b1;
          if (dec.factory && (id_code != code_q)) begin
            code_d   = id_code;
            do_apply = 1'b1;
          end
        end
      end

      S_USB_DET: begin
        if (!vbus_ok || !id_is_float) begin
          state_d = S_IDLE;
        end else if ((tmr_cnt == SDP_END) && !seen_short && !seen_host) begin
          dev_d          = '0;
          dev_d[T_SDP]   = 1'b1;
          route_d        = RT_PRIMARY;
          att_d          = 1'b1;
          state_d        = S_USB_ATT;
        end else if (tmr_cnt >= CDP_END) begin
          dev_d = '0;
          if (seen_short) begin
            dev_d[T_DCP] = 1'b1;
            route_d      = RT_OPEN;
          end else if (seen_host) begin
            dev_d[T_CDP] = 1'b1;
            route_d      = RT_PRIMARY;
          end else begin
            dev_d[T_SDP] = 1'b1;
            route_d      = RT_PRIMARY;
          end
          att_d   = 1'b1;
          state_d = S_USB_ATT;
        end
      end

      S_USB_ATT: begin
        if (!vbus_ok) do_detach = 1'b1;
      end

      default: state_d = S_IDLE;
    endcase

    if (do_apply) begin
      dev_d   = dec.dev;
      jig_d   = dec.jig;
      boot_d  = dec.boot;
      route_d = dec.route;
    end

    if (do_detach) begin
      dev_d   = '0;
      jig_d   = 1'b0;
      boot_d  = 1'b0;
      route_d = RT_OPEN;
      det_d   = 1'b1;
      state_d = S_IDLE;
    end
  end

  // State and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dev_q   <= '0;
      jig_q   <= 1'b0;
      boot_q  <= 1'b0;
      route_q <= RT_OPEN;
      code_q  <= CODE_FLOAT;
      att_q   <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dev_q   <= dev_d;
      jig_q   <= jig_d;
      boot_q  <= boot_d;
      route_q <= route_d;
      code_q  <= code_d;
      att_q   <= att_d;
      det_q   <= det_d;
    end
  end

  assign dev_type   = dev_q;
  assign jig_req    = jig_q;
  assign boot_req   = boot_q;
  assign route_sel  = route_q;
  assign attach_evt = att_q;
  assign detach_evt = det_q;

endmodule

// File: rtl/acc_classifier_chk.sv
module acc_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] dev_type,
  input logic       jig_req,
  input logic       boot_req,
  input logic [1:0] route_sel,
  input logic       attach_evt,
  input logic       detach_evt
);

  p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_type));

  p_evt_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(attach_evt && detach_evt));

  p_attach_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    attach_evt |=> !attach_evt);

  p_clear_needs_detach_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_type == '0 && $past(dev_type) != '0) |-> detach_evt);

  p_jig_factory_r2: assert property (@(posedge clk) disable iff (!rst_n)
    jig_req == (|dev_type[7:4]));

  p_boot_jig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req |-> jig_req);

  p_secondary_uart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (route_sel == 2'b10) |-> (dev_type[6] || dev_type[7]));

  p_ta_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_type[3] |-> (route_sel == 2'b00));

  p_dcp_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_type[2] |-> (route_sel == 2'b00));

  p_detach_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    detach_evt |-> (dev_type == '0 && route_sel == 2'b00 && !jig_req && !boot_req));

endmodule

bind acc_classifier acc_classifier_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_type   (dev_type),
  .jig_req    (jig_req),
  .boot_req   (boot_req),
  .route_sel  (route_sel),
  .attach_evt (attach_evt),
  .detach_evt (detach_evt)
);

// File: tb/tb_acc_classifier.sv
`timescale 1ns/1ps
module tb_acc_classifier;

  localparam int TPM   = 10;
  localparam int DCD_C = 20 * TPM;
  localparam int SDP_C = 130 * TPM;
  localparam int CDP_C = 170 * TPM;
  localparam int ID_C  = 200 * TPM;
  localparam int FLT_C = 70 * TPM;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       vbus_ok;
  logic [4:0] id_code;
  logic       id_float;
  logic       dline_short;
  logic       host_sig;
  logic [8:0] dev_type;
  logic       jig_req;
  logic       boot_req;
  logic [1:0] route_sel;
  logic       attach_evt;
  logic       detach_evt;

  int n_chk = 0;
  int n_bad = 0;
  int n_att = 0;
  int n_det = 0;

  always #2.5 clk = ~clk;

  acc_classifier #(.TICKS_PER_MS(TPM)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .vbus_ok     (vbus_ok),
    .id_code     (id_code),
    .id_float    (id_float),
    .dline_short (dline_short),
    .host_sig    (host_sig),
    .dev_type    (dev_type),
    .jig_req     (jig_req),
    .boot_req    (boot_req),
    .route_sel   (route_sel),
    .attach_evt  (attach_evt),
    .detach_evt  (detach_evt)
  );

  always @(negedge clk) begin
    if (attach_evt) n_att++;
    if (detach_evt) n_det++;
  end

  typedef struct packed {
    logic [4:0] code;
    logic       vb;
    logic [8:0] typ;
    logic       jig;
    logic       boot;
    logic [1:0] rt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'b11000, 1'b0, 9'h010, 1'b1, 1'b0, 2'b01},
    '{5'b11001, 1'b0, 9'h020, 1'b1, 1'b1, 2'b01},
    '{5'b11100, 1'b1, 9'h040, 1'b1, 1'b0, 2'b10},
    '{5'b11101, 1'b0, 9'h080, 1'b1, 1'b1, 2'b10},
    '{5'b10111, 1'b1, 9'h008, 1'b0, 1'b0, 2'b00},
    '{5'b10111, 1'b0, 9'h100, 1'b0, 1'b0, 2'b00},
    '{5'b10101, 1'b0, 9'h100, 1'b0, 1'b0, 2'b00},
    '{5'b11010, 1'b1, 9'h100, 1'b0, 1'b0, 2'b00},
    '{5'b11110, 1'b0, 9'h100, 1'b0, 1'b0, 2'b00},
    '{5'b00000, 1'b0, 9'h100, 1'b0, 1'b0, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string req_of(input logic [4:0] c);
    if (c[4:3] == 2'b11 && c[1] == 1'b0) return "R2";
    if (c == 5'b10111) return "R3";
    return "R4";
  endfunction

  task automatic release_all();
    id_float    = 1'b1;
    id_code     = 5'b11111;
    vbus_ok     = 1'b0;
    dline_short = 1'b0;
    host_sig    = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog R13 actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a0;
    int d0;
    rst_n = 1'b0;
    release_all();
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    // R1 reset state
    check("R1 dev_type", dev_type, 0);
    check("R1 jig", jig_req, 0);
    check("R1 boot", boot_req, 0);
    check("R1 route", route_sel, 0);
    check("R1 events", n_att + n_det, 0);

    // Table of ID classifications (R2, R3, R4) with detach (R12, R7)
    for (int i = 0; i < NV; i++) begin
      a0 = n_att;
      d0 = n_det;
      id_code  = VECS[i].code;
      id_float = 1'b0;
      vbus_ok  = VECS[i].vb;
      wait_cyc(ID_C - 3);
      check({req_of(VECS[i].code), " early"}, dev_type, 0);
      wait_cyc(6);
      check({req_of(VECS[i].code), " type"}, dev_type, VECS[i].typ);
      check({req_of(VECS[i].code), " jig"}, jig_req, VECS[i].jig);
      check({req_of(VECS[i].code), " boot"}, boot_req, VECS[i].boot);
      check({req_of(VECS[i].code), " route"}, route_sel, VECS[i].rt);
      check({req_of(VECS[i].code), " attach"}, n_att, a0 + 1);
      release_all();
      wait_cyc(FLT_C + 6);
      check("R12 cleared", dev_type, 0);
      check("R12 route", route_sel, 0);
      check("R12 detach", n_det, d0 + 1);
    end

    // R5 window restart on code change
    a0 = n_att;
    id_code = 5'b11000; id_float = 1'b0;
    wait_cyc(ID_C / 2);
    id_code = 5'b11001;
    wait_cyc(ID_C - 4);
    check("R5 restart", dev_type, 0);
    wait_cyc(8);
    check("R5 new code", dev_type, 9'h020);
    check("R5 one attach", n_att, a0 + 1);

    // R6 live factory mode switch
    d0 = n_det;
    id_code = 5'b11100;
    wait_cyc(3);
    check("R6 type", dev_type, 9'h040);
    check("R6 route", route_sel, 2'b10);
    check("R6 boot", boot_req, 0);
    check("R6 jig", jig_req, 1);
    check("R6 no events", (n_att - a0) + (n_det - d0), 1);
    id_code = 5'b10101;
    wait_cyc(5);
    check("R6 non-factory ignored", dev_type, 9'h040);
    vbus_ok = 1'b1;
    wait_cyc(10);
    vbus_ok = 1'b0;
    wait_cyc(10);
    check("R6 vbus ignored", dev_type, 9'h040);
    id_code = 5'b11100;
    wait_cyc(3);

    // R7 short float keeps mode, long float exits
    id_float = 1'b1;
    wait_cyc(FLT_C - 20);
    id_float = 1'b0;
    wait_cyc(5);
    check("R7 short float", dev_type, 9'h040);
    check("R7 no detach", n_det, d0);
    id_code = 5'b11111;
    wait_cyc(FLT_C - 3);
    check("R7 before exit", dev_type, 9'h040);
    wait_cyc(8);
    check("R7 exit", dev_type, 0);
    check("R7 jig clear", jig_req, 0);
    check("R7 detach", n_det, d0 + 1);
    release_all();
    wait_cyc(5);

    // R12 unknown accessory detaches at once on float
    d0 = n_det;
    id_code = 5'b10101; id_float = 1'b0;
    wait_cyc(ID_C + 3);
    check("R4 unknown", dev_type, 9'h100);
    release_all();
    wait_cyc(3);
    check("R12 immediate detach", n_det, d0 + 1);
    check("R12 cleared", dev_type, 0);

    // R8 standard port
    a0 = n_att; d0 = n_det;
    vbus_ok = 1'b1;
    wait_cyc(SDP_C - 2);
    check("R8 early", dev_type, 0);
    wait_cyc(5);
    check("R8 type", dev_type, 9'h001);
    check("R8 route", route_sel, 2'b01);
    check("R8 attach", n_att, a0 + 1);
    vbus_ok = 1'b0;
    wait_cyc(3);
    check("R12 vbus loss", dev_type, 0);
    check("R12 detach", n_det, d0 + 1);
    wait_cyc(5);

    // R11 short only during contact detect is ignored
    vbus_ok = 1'b1; dline_short = 1'b1;
    wait_cyc(DCD_C / 2);
    dline_short = 1'b0;
    wait_cyc(SDP_C + 3 - DCD_C / 2);
    check("R11 dcd flags ignored", dev_type, 9'h001);
    release_all();
    wait_cyc(5);

    // R9 charging downstream port
    vbus_ok = 1'b1;
    wait_cyc(500);
    host_sig = 1'b1;
    wait_cyc(SDP_C + 3 - 500);
    check("R9 none at 130", dev_type, 0);
    wait_cyc(CDP_C - SDP_C);
    check("R9 type", dev_type, 9'h002);
    check("R9 route", route_sel, 2'b01);
    release_all();
    wait_cyc(5);

    // R10 dedicated charger beats host signalling
    vbus_ok = 1'b1;
    wait_cyc(300);
    dline_short = 1'b1; host_sig = 1'b1;
    wait_cyc(CDP_C + 3 - 300);
    check("R10 type", dev_type, 9'h004);
    check("R10 route", route_sel, 2'b00);
    release_all();
    wait_cyc(5);

    // R12 vbus lost mid-detection: no event
    a0 = n_att; d0 = n_det;
    vbus_ok = 1'b1;
    wait_cyc(600);
    vbus_ok = 1'b0;
    wait_cyc(SDP_C);
    check("R12 abort type", dev_type, 0);
    check("R12 abort events", (n_att - a0) + (n_det - d0), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule